// File: doc/BRIEF.md
# Dual-Port Word Memory with Contention Arbitration

This block is a clocked two-port memory of 4096 words with a configurable word width (9 bits by default, 8 also supported). Ports A and B are fully independent. Each has an active-low select, an active-low output enable, a read/not-write control, an address and separate write and read data buses. A read is registered: the word and a valid flag appear on the port's outputs one clock after the read cycle. A write commits at the clock edge that closes its cycle.

When both ports are selected at the same address in the same cycle and at least one of them writes, the block resolves the clash. A role strap decides where the answer comes from. In master role, an internal arbiter picks a winner. It drives an active-low busy output toward the losing port only, and blocks that port's write and read. In slave role, the busy outputs stay idle. Each port's active-low busy input comes from an external master and blocks that port's write and read. This lets several devices be placed side by side to form wider words while a single arbiter rules the whole set.

Top module: `dpram_arb`

## Requirements
- R1: A selected read (select low, read/not-write high, output enable low) that is not blocked raises the port's read-valid flag in the next cycle. That cycle's read data is the word last committed at the address. The array holds 4096 words, and the word width parameter accepts 8 and 9.
- R2: While a port's select is high, the port commits no write, whatever its other controls. In the next cycle its read-valid is 0 and its read data is all zeros.
- R3: With select low and read/not-write low, the port commits its write data whatever its output enable. In the next cycle its read-valid is 0 and its read data is zero.
- R4: A selected read with output enable high returns read-valid 0 and read data zero in the next cycle.
- R5: Contention exists only when both ports are selected, their addresses are equal and at least one of them writes. Two reads of the same address assert no busy.
- R6: In master role (strap high), each busy output is active low and goes low only toward the losing port of a contention. On a tie between newcomers, port A wins. A port that was selected at the same address in the previous cycle keeps priority over a newcomer. When both held the address and contention continues, the earlier winner stays the winner.
- R7: A port whose busy is asserted commits no write. Its read-valid is 0 in the next cycle.
- R8: In slave role (strap low), both busy outputs stay high. A port whose busy input is low is blocked as in R7, and busy inputs are ignored in master role.
- R9: A word written by one port is returned to the other port's read issued in the cycle after the write commits. A read of the same word in the same cycle as the write returns the previous contents.
- R10: If both ports commit writes to one address in the same cycle, which only slave role allows, port A's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master (internal arbiter), 0 = slave (external busy) |
| a_sel_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_rnw | input | 1 | Port A 1 = read, 0 = write |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_busy_n_i | input | 1 | Port A busy input (slave role), active low |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| a_busy_n_o | output | 1 | Port A busy output (master role), active low |
| b_sel_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_rnw | input | 1 | Port B 1 = read, 0 = write |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_busy_n_i | input | 1 | Port B busy input (slave role), active low |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |
| b_busy_n_o | output | 1 | Port B busy output (master role), active low |

## Verification
Assertions check on every cycle that a master-role contention asserts exactly one busy and that newcomers lose to port A. They also check that same-address reads raise no busy, that slave role keeps both busy outputs idle, and that any non-read or blocked cycle yields no valid read data next cycle. Only the bench scenarios, through a reference array, can show that a blocked write truly left the stored word intact. The same holds for holder priority over several cycles, the one-cycle flow-through between ports, and port A's precedence when both write one word.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int PORTS = 2;
    localparam int PA    = 0;
    localparam int PB    = 1;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_MUTE  = 2'd3
    } op_e;

    function automatic op_e decode_op(input logic sel_n, input logic oe_n, input logic rnw);
        if (sel_n)
            return OP_IDLE;
        else if (!rnw)
            return OP_WRITE;
        else if (oe_n)
            return OP_MUTE;
        else
            return OP_READ;
    endfunction

    function automatic logic is_active(input op_e op);
        return op != OP_IDLE;
    endfunction

endpackage

// File: rtl/dpram_array.sv
module dpram_array
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 9
) (
    input  logic                          clk,
    input  logic [PORTS-1:0]              we_i,
    input  logic [PORTS-1:0][ADDR_W-1:0]  addr_i,
    input  logic [PORTS-1:0][DATA_W-1:0]  wdata_i,
    output logic [PORTS-1:0][DATA_W-1:0]  q_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Port B is written first so that port A's word remains on a shared address.
    always_ff @(posedge clk) begin
        if (we_i[PB])
            store[addr_i[PB]] <= wdata_i[PB];
        if (we_i[PA])
            store[addr_i[PA]] <= wdata_i[PA];
        for (int p = 0; p < PORTS; p++)
            q_o[p] <= store[addr_i[p]];
    end

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  role_e                         role_i,
    input  logic [PORTS-1:0]              act_i,
    input  logic [PORTS-1:0]              wr_i,
    input  logic [PORTS-1:0][ADDR_W-1:0]  addr_i,
    input  logic [PORTS-1:0]              busy_in_n_i,
    output logic [PORTS-1:0]              busy_eff_o,
    output logic [PORTS-1:0]              busy_out_n_o
);
    logic [PORTS-1:0]             prev_act;
    logic [PORTS-1:0][ADDR_W-1:0] prev_addr;
    logic                         prev_clash;
    logic                         prev_win_b;

    logic                         same_addr;
    logic                         clash;
    logic [PORTS-1:0]             hold;
    logic                         win_b;

    always_comb begin
        same_addr = addr_i[PA] == addr_i[PB];
        clash     = act_i[PA] & act_i[PB] & same_addr & (wr_i[PA] | wr_i[PB]);
        for (int p = 0; p < PORTS; p++)
            hold[p] = act_i[p] & prev_act[p] & (prev_addr[p] == addr_i[p]);
        win_b = clash & ((hold[PB] & ~hold[PA]) |
                         (hold[PA] & hold[PB] & prev_clash & prev_win_b));
    end

    always_comb begin
        if (role_i == ROLE_MASTER) begin
            busy_eff_o[PA]   = clash & win_b;
            busy_eff_o[PB]   = clash & ~win_b;
            busy_out_n_o     = ~busy_eff_o;
        end else begin
            busy_eff_o       = ~busy_in_n_i;
            busy_out_n_o     = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act   <= '0;
            prev_addr  <= '0;
            prev_clash <= 1'b0;
            prev_win_b <= 1'b0;
        end else begin
            prev_act   <= act_i;
            prev_addr  <= addr_i;
            prev_clash <= clash;
            prev_win_b <= win_b;
        end
    end

    // R5 R6
    // R6
    master_one_loser_chk: assert property (@(posedge clk) disable iff (rst)
        (role_i == ROLE_MASTER && act_i == 2'b11 && addr_i[PA] == addr_i[PB] && wr_i != 2'b00)
        |-> $countones(busy_out_n_o) == 1);

    // R6
    newcomer_tie_a_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (role_i == ROLE_MASTER && act_i == 2'b11 && addr_i[PA] == addr_i[PB] &&
         wr_i != 2'b00 && !$past(act_i[PA]) && !$past(act_i[PB]))
        |-> (busy_out_n_o == 2'b01));

    // R5
    shared_read_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i == 2'b11 && wr_i == 2'b00 && role_i == ROLE_MASTER) |-> busy_out_n_o == 2'b11);

    // R8
    slave_busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (role_i == ROLE_SLAVE) |-> busy_out_n_o == 2'b11);

endmodule

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] q_i,
    output logic              we_o,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic rvalid_q;

    assign we_o = (op_i == OP_WRITE) && !busy_i;

    always_ff @(posedge clk) begin
        if (rst)
            rvalid_q <= 1'b0;
        else
            rvalid_q <= (op_i == OP_READ) && !busy_i;
    end

    assign rvalid_o = rvalid_q;
    assign rdata_o  = rvalid_q ? q_i : '0;

    // R2 R3 R4
    no_read_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_READ) |=> !rvalid_o);

    // R7 R8
    busy_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> !rvalid_o);

    // R7
    busy_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !we_o);

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_master,
    input  logic              a_sel_n,
    input  logic              a_oe_n,
    input  logic              a_rnw,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_busy_n_i,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    output logic              a_busy_n_o,
    input  logic              b_sel_n,
    input  logic              b_oe_n,
    input  logic              b_rnw,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_busy_n_i,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_busy_n_o
);
    op_e                          op_v    [PORTS];
    logic [PORTS-1:0]             act_v;
    logic [PORTS-1:0]             wr_v;
    logic [PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [PORTS-1:0][DATA_W-1:0] wdata_v;
    logic [PORTS-1:0]             busy_in_n_v;
    logic [PORTS-1:0]             busy_eff_v;
    logic [PORTS-1:0]             busy_out_n_v;
    logic [PORTS-1:0]             we_v;
    logic [PORTS-1:0][DATA_W-1:0] q_v;
    logic [PORTS-1:0]             rvalid_v;
    logic [PORTS-1:0][DATA_W-1:0] rdata_v;
    role_e                        role;

    assign role            = role_master ? ROLE_MASTER : ROLE_SLAVE;
    assign op_v[PA]        = decode_op(a_sel_n, a_oe_n, a_rnw);
    assign op_v[PB]        = decode_op(b_sel_n, b_oe_n, b_rnw);
    assign addr_v          = {b_addr, a_addr};
    assign wdata_v         = {b_wdata, a_wdata};
    assign busy_in_n_v     = {b_busy_n_i, a_busy_n_i};

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            assign act_v[p] = is_active(op_v[p]);
            assign wr_v[p]  = op_v[p] == OP_WRITE;

            dpram_port #(.DATA_W(DATA_W)) u_port (
                .clk      (clk),
                .rst      (rst),
                .op_i     (op_v[p]),
                .busy_i   (busy_eff_v[p]),
                .q_i      (q_v[p]),
                .we_o     (we_v[p]),
                .rvalid_o (rvalid_v[p]),
                .rdata_o  (rdata_v[p])
            );
        end
    endgenerate

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arbiter (
        .clk          (clk),
        .rst          (rst),
        .role_i       (role),
        .act_i        (act_v),
        .wr_i         (wr_v),
        .addr_i       (addr_v),
        .busy_in_n_i  (busy_in_n_v),
        .busy_eff_o   (busy_eff_v),
        .busy_out_n_o (busy_out_n_v)
    );

    dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .we_i    (we_v),
        .addr_i  (addr_v),
        .wdata_i (wdata_v),
        .q_o     (q_v)
    );

    assign a_rdata    = rdata_v[PA];
    assign b_rdata    = rdata_v[PB];
    assign a_rvalid   = rvalid_v[PA];
    assign b_rvalid   = rvalid_v[PB];
    assign a_busy_n_o = busy_out_n_v[PA];
    assign b_busy_n_o = busy_out_n_v[PB];

    // R2
    idle_port_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        a_sel_n |=> (!a_rvalid && a_rdata == '0));

    // R8
    slave_busy_in_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (!role_master && !b_busy_n_i) |=> !b_rvalid);

endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic role_master = 1'b1;
    logic a_sel_n = 1'b1, a_oe_n = 1'b1, a_rnw = 1'b1, a_busy_n_i = 1'b1;
    logic b_sel_n = 1'b1, b_oe_n = 1'b1, b_rnw = 1'b1, b_busy_n_i = 1'b1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_rvalid, b_rvalid, a_busy_n_o, b_busy_n_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .role_master(role_master),
        .a_sel_n(a_sel_n), .a_oe_n(a_oe_n), .a_rnw(a_rnw), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_busy_n_i(a_busy_n_i), .a_rdata(a_rdata),
        .a_rvalid(a_rvalid), .a_busy_n_o(a_busy_n_o),
        .b_sel_n(b_sel_n), .b_oe_n(b_oe_n), .b_rnw(b_rnw), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_busy_n_i(b_busy_n_i), .b_rdata(b_rdata),
        .b_rvalid(b_rvalid), .b_busy_n_o(b_busy_n_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic          v_a;
        logic [DW-1:0] d_a;
        logic          v_b;
        logic [DW-1:0] d_b;
    } exp_t;

    exp_t  exp_q[$];
    string tag_a_q[$];
    string tag_b_q[$];

    logic [DW-1:0] ref_mem [DEPTH];

    // reference arbitration history
    logic          m_pact_a, m_pact_b, m_pclash, m_pwin_b;
    logic [AW-1:0] m_paddr_a, m_paddr_b;
    int            last_wr_a, last_wr_b;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_model();
        m_pact_a = 0; m_pact_b = 0; m_pclash = 0; m_pwin_b = 0;
        m_paddr_a = '0; m_paddr_b = '0;
        last_wr_a = -1; last_wr_b = -1;
    endtask

    task automatic do_reset(input logic master);
        @(negedge clk);
        rst = 1'b1; role_master = master;
        a_sel_n = 1; b_sel_n = 1; a_busy_n_i = 1; b_busy_n_i = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    // Drive one cycle on both ports, check busy now, queue expected read results.
    task automatic cycle(
        input logic as, input logic aoe, input logic arnw, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
        input logic bs, input logic boe, input logic brnw, input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
        input logic abi, input logic bbi, input string force_tag);
        logic en_a, en_b, wr_a, wr_b, clash, hold_a, hold_b, win_b, bz_a, bz_b, v_a, v_b;
        string tg_a, tg_b, tg_bz;
        exp_t e;
        @(negedge clk);
        a_sel_n = as; a_oe_n = aoe; a_rnw = arnw; a_addr = aad; a_wdata = awd; a_busy_n_i = abi;
        b_sel_n = bs; b_oe_n = boe; b_rnw = brnw; b_addr = bad; b_wdata = bwd; b_busy_n_i = bbi;
        #1;
        en_a = !as; en_b = !bs;
        wr_a = en_a && !arnw; wr_b = en_b && !brnw;
        clash  = en_a && en_b && (aad == bad) && (wr_a || wr_b);
        hold_a = en_a && m_pact_a && (m_paddr_a == aad);
        hold_b = en_b && m_pact_b && (m_paddr_b == bad);
        win_b  = clash && ((hold_b && !hold_a) || (hold_a && hold_b && m_pclash && m_pwin_b));
        if (role_master) begin
            bz_a = clash && win_b; bz_b = clash && !win_b;
            tg_bz = (en_a && en_b && aad == bad && !clash) ? "R5" : "R6";
        end else begin
            bz_a = !abi; bz_b = !bbi; tg_bz = "R8";
        end
        if (force_tag != "") tg_bz = force_tag;
        check({tg_bz, " busy A"}, 32'(a_busy_n_o), role_master ? 32'(!bz_a) : 32'd1);
        check({tg_bz, " busy B"}, 32'(b_busy_n_o), role_master ? 32'(!bz_b) : 32'd1);

        v_a = en_a && arnw && !aoe && !bz_a;
        v_b = en_b && brnw && !boe && !bz_b;
        e.v_a = v_a; e.d_a = v_a ? ref_mem[aad] : '0;
        e.v_b = v_b; e.d_b = v_b ? ref_mem[bad] : '0;

        if (!en_a) tg_a = "R2";
        else if (wr_a) tg_a = bz_a ? "R7" : "R3";
        else if (aoe) tg_a = "R4";
        else if (bz_a) tg_a = role_master ? "R7" : "R8";
        else if (last_wr_b == int'(aad)) tg_a = "R9";
        else tg_a = "R1";
        if (!en_b) tg_b = "R2";
        else if (wr_b) tg_b = bz_b ? "R7" : "R3";
        else if (boe) tg_b = "R4";
        else if (bz_b) tg_b = role_master ? "R7" : "R8";
        else if (last_wr_a == int'(bad)) tg_b = "R9";
        else tg_b = "R1";
        if (force_tag != "") begin tg_a = force_tag; tg_b = force_tag; end
        exp_q.push_back(e);
        tag_a_q.push_back(tg_a);
        tag_b_q.push_back(tg_b);

        last_wr_a = (wr_a && !bz_a) ? int'(aad) : -1;
        last_wr_b = (wr_b && !bz_b) ? int'(bad) : -1;
        if (wr_b && !bz_b) ref_mem[bad] = bwd;
        if (wr_a && !bz_a) ref_mem[aad] = awd;
        m_pact_a = en_a; m_pact_b = en_b;
        m_paddr_a = aad; m_paddr_b = bad;
        m_pclash = clash; m_pwin_b = win_b;
    endtask

    task automatic idle_cycle();
        cycle(1, 1, 1, '0, '0, 1, 1, 1, '0, '0, 1, 1, "");
    endtask

    // Monitor: pops one expected entry per registered result.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string ta, tb;
                e = exp_q.pop_front();
                ta = tag_a_q.pop_front();
                tb = tag_b_q.pop_front();
                check({ta, " rvalid A"}, 32'(a_rvalid), 32'(e.v_a));
                check({ta, " rdata A"},  32'(a_rdata),  32'(e.d_a));
                check({tb, " rvalid B"}, 32'(b_rvalid), 32'(e.v_b));
                check({tb, " rdata B"},  32'(b_rdata),  32'(e.d_b));
            end
        end
    end

    initial begin
        repeat (80000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        clear_model();
        do_reset(1'b1);
        #1;
        // R2 reset state: outputs quiet
        check("R2 reset rvalid A", 32'(a_rvalid), 0);
        check("R2 reset rdata B", 32'(b_rdata), 0);
        check("R6 reset busy A", 32'(a_busy_n_o), 1);
        check("R6 reset busy B", 32'(b_busy_n_o), 1);

        // R1 fill the full array through port A
        for (int i = 0; i < DEPTH; i++)
            cycle(0, 1, 0, AW'(i), DW'(i * 37 + 5), 1, 1, 1, '0, '0, 1, 1, "R1");
        // R1 read back the two ends through port B
        cycle(1, 1, 1, '0, '0, 0, 0, 1, '0, '0, 1, 1, "R1");
        cycle(1, 1, 1, '0, '0, 0, 0, 1, AW'(DEPTH - 1), '0, 1, 1, "R1");

        // R2 deselected port with write request changes nothing
        cycle(1, 0, 0, 12'd20, 9'h1AA, 1, 1, 1, '0, '0, 1, 1, "R2");
        cycle(0, 0, 1, 12'd20, '0, 1, 1, 1, '0, '0, 1, 1, "R2");
        // R3 write with output enable low
        cycle(0, 0, 0, 12'd21, 9'h0F0, 1, 1, 1, '0, '0, 1, 1, "R3");
        // R4 selected read with output enable high
        cycle(0, 1, 1, 12'd21, '0, 1, 1, 1, '0, '0, 1, 1, "R4");
        idle_cycle();
        // R5 two reads of one address
        cycle(0, 0, 1, 12'd30, '0, 0, 0, 1, 12'd30, '0, 1, 1, "R5");
        idle_cycle();
        // R6 tie between newcomers: A write, B read -> B busy, R9 flow next cycle
        cycle(0, 1, 0, 12'd40, 9'h155, 0, 0, 1, 12'd40, '0, 1, 1, "R6");
        cycle(1, 1, 1, '0, '0, 0, 0, 1, 12'd40, '0, 1, 1, "R9");
        idle_cycle();
        // R6 holder priority: B holds 50, A newcomer write loses, R7 write blocked
        cycle(1, 1, 1, '0, '0, 0, 0, 1, 12'd50, '0, 1, 1, "");
        cycle(0, 1, 0, 12'd50, 9'h0AB, 0, 0, 1, 12'd50, '0, 1, 1, "R6");
        cycle(0, 1, 0, 12'd50, 9'h0AB, 0, 0, 1, 12'd50, '0, 1, 1, "R7");
        cycle(0, 0, 1, 12'd50, '0, 1, 1, 1, '0, '0, 1, 1, "R7");
        // R8 busy inputs ignored in master role
        cycle(0, 0, 1, 12'd60, '0, 0, 0, 1, 12'd61, '0, 0, 0, "R8");
        idle_cycle();

        // random master traffic on a narrow window
        for (int n = 0; n < 3000; n++)
            cycle(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 7)), DW'($urandom),
                  1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 7)), DW'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "");
        idle_cycle();

        // slave role
        do_reset(1'b0);
        // R10 both write one address, no busy
        cycle(0, 1, 0, 12'd70, 9'h011, 0, 1, 0, 12'd70, 9'h122, 1, 1, "R10");
        cycle(0, 0, 1, 12'd70, '0, 1, 1, 1, '0, '0, 1, 1, "R10");
        // R9 same-cycle read returns old contents, next cycle new
        cycle(0, 1, 0, 12'd71, 9'h0C3, 0, 0, 1, 12'd71, '0, 1, 1, "R9");
        cycle(1, 1, 1, '0, '0, 0, 0, 1, 12'd71, '0, 1, 1, "R9");
        // R8 busy input blocks write on B
        cycle(1, 1, 1, '0, '0, 0, 1, 0, 12'd72, 9'h1FF, 1, 0, "R8");
        cycle(1, 1, 1, '0, '0, 0, 0, 1, 12'd72, '0, 1, 1, "R8");
        for (int n = 0; n < 3000; n++)
            cycle(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 7)), DW'($urandom),
                  1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 7)), DW'($urandom),
                  1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), "");
        idle_cycle();
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule